// File: doc/BRIEF.md
# Processor Interrupt Presenter

This block sits between an interrupt source controller and one processor. It keeps the processor's current priority threshold, an inter-processor interrupt request priority, the id and priority of the one interrupt now offered to the processor, and a flag that records a refused delivery. A lower number means a more favoured priority; the value 0xFF is the least favoured and means "nothing".

The source controller offers an interrupt as an id and a priority. The presenter either takes it, handing back any id it displaces, or refuses it and remembers that a later redelivery pass is due. The processor acts on the presenter through four operations: accept the pending interrupt, change the threshold, post an inter-processor request, and end an interrupt. The presenter drives a level interrupt line to the processor. It also drives pulses back toward the source controller: a displaced id from either path, a redelivery request, and an end-of-interrupt forward. A displaced interrupt is never queued. It goes back to the source controller for redelivery.

Top module: `irq_presenter`

## Requirements
- R1: An offer at priority p is taken only if p is below the threshold, below the request priority and below the pending priority. When it is taken, the earlier pending id is reported on the offer reject output, and the new id and priority become pending.
- R2: A refused offer sets the redelivery flag. The flag shows as a redelivery pulse on the next request-priority raise, threshold raise or end-of-interrupt.
- R3: `irq_out` is high exactly when the pending id is nonzero and the pending priority is below the threshold.
- R4: Accept (op_code 0) returns `acc_word` = {threshold[7:0], pending id[23:0]} as it stood before the operation. If the id was nonzero, the threshold takes the pending priority, the pending priority becomes 0xFF and the id becomes 0.
- R5: Setting the request priority (op_code 2, value in op_data[7:0]) loads it. If the value is below the threshold and no greater than the pending priority, the old pending id is rejected, the pending priority takes the value and the pending id becomes the inter-processor id 2.
- R6: When a request-priority write raises the value, the redelivery flag is cleared and a redelivery pulse is issued if the flag was set.
- R7: Raising the threshold (op_code 1, value in op_data[7:0]) loads it. If the request priority is below the new threshold and no greater than the pending priority, id 2 becomes pending at the request priority. The redelivery flag is cleared and becomes a redelivery pulse.
- R8: Writing the threshold with its current value has no effect. Writing a smaller value loads it and, if the value is no greater than the pending priority, rejects the pending id, clears it and sets the pending priority to 0xFF.
- R9: End-of-interrupt (op_code 3) takes op_data[31:24] through the threshold-raise path of R7. It forwards op_data[23:0] on `eoi_id` unless that value is 2.
- R10: A displaced id equal to 2 or to 0 is never reported on either reject output.
- R11: Reset sets the threshold to 0, the request priority to 0xFF, the pending priority to 0xFF and the pending id to 0.
- R12: An operation and an offer in the same cycle are applied operation first. All results, including the answer to the offer, appear in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A processor operation is present |
| op_code | input | 2 | 0 accept, 1 set threshold, 2 set request priority, 3 end-of-interrupt |
| op_data | input | 32 | Operand: priority in [7:0], or {priority, id} for end-of-interrupt |
| offer_valid | input | 1 | The source controller offers an interrupt |
| offer_id | input | 24 | Offered source id |
| offer_prio | input | 8 | Offered priority |
| irq_out | output | 1 | Interrupt line to the processor |
| acc_valid | output | 1 | Accept result is valid |
| acc_word | output | 32 | {threshold, pending id} returned by accept |
| offer_done | output | 1 | The offer from the previous cycle was judged |
| offer_taken | output | 1 | That offer was taken |
| op_rej_valid | output | 1 | An operation displaced a real source |
| op_rej_id | output | 24 | Id displaced by the operation |
| off_rej_valid | output | 1 | An offer displaced a real source |
| off_rej_id | output | 24 | Id displaced by the offer |
| resend_req | output | 1 | Redelivery pass requested |
| eoi_valid | output | 1 | End-of-interrupt forward is valid |
| eoi_id | output | 24 | Source id whose interrupt ended |

## Verification
The bench sweeps offer priorities against a grid of threshold and request-priority settings, and it includes the values that tie each bound. A design that used "no greater than" in the offer test would take an offer whose priority equals a bound. That would show as a wrong `offer_taken` and a wrong accept word. The redelivery flag is checked by raising the request priority after each sweep step, so a flag that is lost or never cleared gives a wrong pulse. Directed cases cover a threshold rewrite with an equal value, an end-of-interrupt for id 2, the displacement of a pending inter-processor request by an offer, and same-cycle operation plus offer. A design that judged the offer before the operation would take an offer that the new threshold should refuse.

// File: rtl/irq_presenter_pkg.sv
package irq_presenter_pkg;

    parameter int PRIO_W = 8;
    parameter int ID_W   = 24;
    localparam int WORD_W = PRIO_W + ID_W;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [ID_W-1:0]   src_t;

    localparam prio_t PRIO_NONE = '1;

    typedef enum logic [1:0] {
        OP_ACCEPT   = 2'd0,
        OP_SET_CPPR = 2'd1,
        OP_SET_MFRR = 2'd2,
        OP_EOI      = 2'd3
    } pres_op_e;

    typedef struct packed {
        prio_t cppr;
        prio_t mfrr;
        prio_t pend;
        src_t  xisr;
        logic  need;
    } pres_state_t;

    typedef struct packed {
        logic              acc_vld;
        logic [WORD_W-1:0] acc_word;
        logic              done;
        logic              taken;
        logic              op_rej_vld;
        src_t              op_rej_id;
        logic              off_rej_vld;
        src_t              off_rej_id;
        logic              resend;
        logic              eoi_vld;
        src_t              eoi_id;
    } pres_out_t;

endpackage

// File: rtl/ipr_cmd_apply.sv
module ipr_cmd_apply
    import irq_presenter_pkg::*;
#(
    parameter int IPI_ID = 2
) (
    input  logic              op_valid,
    input  pres_op_e          op_code,
    input  logic [WORD_W-1:0] op_data,
    input  pres_state_t       cur,
    output pres_state_t       nxt,
    output logic              rej_vld,
    output src_t              rej_id,
    output logic              resend,
    output logic              eoi_vld,
    output src_t              eoi_id,
    output logic              acc_vld,
    output logic [WORD_W-1:0] acc_word
);

    localparam src_t IPI_SRC = src_t'(IPI_ID);

    prio_t arg_p;
    prio_t eoi_p;
    prio_t down_v;
    logic  down_en;
    src_t  rej_raw;

    assign arg_p  = op_data[PRIO_W-1:0];
    assign eoi_p  = op_data[ID_W +: PRIO_W];
    assign eoi_id = op_data[ID_W-1:0];

    always_comb begin
        nxt      = cur;
        rej_raw  = '0;
        resend   = 1'b0;
        eoi_vld  = 1'b0;
        acc_vld  = 1'b0;
        acc_word = {cur.cppr, cur.xisr};
        down_en  = 1'b0;
        down_v   = arg_p;

        if (op_valid) begin
            unique case (op_code)
                OP_ACCEPT: begin
                    acc_vld = 1'b1;
                    if (cur.xisr != '0) begin
                        nxt.cppr = cur.pend;
                        nxt.pend = PRIO_NONE;
                        nxt.xisr = '0;
                    end
                end
                OP_SET_CPPR: begin
                    if (arg_p > cur.cppr) begin
                        down_en = 1'b1;
                    end else if (arg_p < cur.cppr) begin
                        nxt.cppr = arg_p;
                        if (arg_p <= cur.pend) begin
                            rej_raw  = cur.xisr;
                            nxt.xisr = '0;
                            nxt.pend = PRIO_NONE;
                        end
                    end
                end
                OP_SET_MFRR: begin
                    nxt.mfrr = arg_p;
                    if (arg_p < cur.cppr && arg_p <= cur.pend) begin
                        rej_raw  = cur.xisr;
                        nxt.pend = arg_p;
                        nxt.xisr = IPI_SRC;
                    end
                    if (arg_p > cur.mfrr) begin
                        resend   = cur.need;
                        nxt.need = 1'b0;
                    end
                end
                OP_EOI: begin
                    down_en = 1'b1;
                    down_v  = eoi_p;
                    eoi_vld = (eoi_id != IPI_SRC);
                end
                default: ;
            endcase
        end

        if (down_en) begin
            nxt.cppr = down_v;
            if (cur.mfrr < down_v && cur.mfrr <= cur.pend) begin
                nxt.pend = cur.mfrr;
                nxt.xisr = IPI_SRC;
            end
            resend   = cur.need;
            nxt.need = 1'b0;
        end
    end

    assign rej_id  = rej_raw;
    assign rej_vld = (rej_raw != '0) && (rej_raw != IPI_SRC);

endmodule

// File: rtl/ipr_offer_judge.sv
module ipr_offer_judge
    import irq_presenter_pkg::*;
#(
    parameter int IPI_ID = 2
) (
    input  logic        offer_valid,
    input  src_t        offer_id,
    input  prio_t       offer_prio,
    input  pres_state_t cur,
    output pres_state_t nxt,
    output logic        taken,
    output logic        rej_vld,
    output src_t        rej_id
);

    localparam src_t IPI_SRC = src_t'(IPI_ID);

    logic fits;
    src_t rej_raw;

    assign fits = (offer_prio < cur.cppr) && (offer_prio < cur.mfrr) &&
                  (offer_prio < cur.pend);

    always_comb begin
        nxt     = cur;
        taken   = 1'b0;
        rej_raw = '0;
        if (offer_valid) begin
            if (fits) begin
                taken    = 1'b1;
                rej_raw  = cur.xisr;
                nxt.xisr = offer_id;
                nxt.pend = offer_prio;
            end else begin
                nxt.need = 1'b1;
            end
        end
    end

    assign rej_id  = rej_raw;
    assign rej_vld = (rej_raw != '0) && (rej_raw != IPI_SRC);

endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import irq_presenter_pkg::*;
#(
    parameter int IPI_ID = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [WORD_W-1:0] op_data,
    input  logic              offer_valid,
    input  logic [ID_W-1:0]   offer_id,
    input  logic [PRIO_W-1:0] offer_prio,
    output logic              irq_out,
    output logic              acc_valid,
    output logic [WORD_W-1:0] acc_word,
    output logic              offer_done,
    output logic              offer_taken,
    output logic              op_rej_valid,
    output logic [ID_W-1:0]   op_rej_id,
    output logic              off_rej_valid,
    output logic [ID_W-1:0]   off_rej_id,
    output logic              resend_req,
    output logic              eoi_valid,
    output logic [ID_W-1:0]   eoi_id
);

    localparam pres_state_t STATE_RST = '{
        cppr: '0, mfrr: PRIO_NONE, pend: PRIO_NONE, xisr: '0, need: 1'b0
    };

    pres_state_t state_q, state_d, after_op;
    pres_out_t   out_q, out_d;

    logic              c_rej_vld, c_resend, c_eoi_vld, c_acc_vld;
    src_t              c_rej_id, c_eoi_id;
    logic [WORD_W-1:0] c_acc_word;
    logic              o_taken, o_rej_vld;
    src_t              o_rej_id;

    ipr_cmd_apply #(.IPI_ID(IPI_ID)) u_cmd (
        .op_valid (op_valid),
        .op_code  (pres_op_e'(op_code)),
        .op_data  (op_data),
        .cur      (state_q),
        .nxt      (after_op),
        .rej_vld  (c_rej_vld),
        .rej_id   (c_rej_id),
        .resend   (c_resend),
        .eoi_vld  (c_eoi_vld),
        .eoi_id   (c_eoi_id),
        .acc_vld  (c_acc_vld),
        .acc_word (c_acc_word)
    );

    ipr_offer_judge #(.IPI_ID(IPI_ID)) u_judge (
        .offer_valid (offer_valid),
        .offer_id    (offer_id),
        .offer_prio  (offer_prio),
        .cur         (after_op),
        .nxt         (state_d),
        .taken       (o_taken),
        .rej_vld     (o_rej_vld),
        .rej_id      (o_rej_id)
    );

    always_comb begin
        out_d             = '0;
        out_d.acc_vld     = c_acc_vld;
        out_d.acc_word    = c_acc_word;
        out_d.done        = offer_valid;
        out_d.taken       = o_taken;
        out_d.op_rej_vld  = c_rej_vld;
        out_d.op_rej_id   = c_rej_id;
        out_d.off_rej_vld = o_rej_vld;
        out_d.off_rej_id  = o_rej_id;
        out_d.resend      = c_resend;
        out_d.eoi_vld     = c_eoi_vld;
        out_d.eoi_id      = c_eoi_id;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STATE_RST;
            out_q   <= '0;
        end else begin
            state_q <= state_d;
            out_q   <= out_d;
        end
    end

    assign irq_out       = (state_q.xisr != '0) && (state_q.pend < state_q.cppr);
    assign acc_valid     = out_q.acc_vld;
    assign acc_word      = out_q.acc_word;
    assign offer_done    = out_q.done;
    assign offer_taken   = out_q.taken;
    assign op_rej_valid  = out_q.op_rej_vld;
    assign op_rej_id     = out_q.op_rej_id;
    assign off_rej_valid = out_q.off_rej_vld;
    assign off_rej_id    = out_q.off_rej_id;
    assign resend_req    = out_q.resend;
    assign eoi_valid     = out_q.eoi_vld;
    assign eoi_id        = out_q.eoi_id;

endmodule

// File: rtl/ipr_checker.sv
module ipr_checker
    import irq_presenter_pkg::*;
#(
    parameter int IPI_ID = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [1:0]  op_code,
    input logic [PRIO_W-1:0] op_prio,
    input logic        offer_valid,
    input logic        irq_out,
    input logic        acc_valid,
    input logic        offer_done,
    input logic        offer_taken,
    input logic        op_rej_valid,
    input logic [ID_W-1:0] op_rej_id,
    input logic        off_rej_valid,
    input logic [ID_W-1:0] off_rej_id,
    input logic        resend_req,
    input logic        eoi_valid,
    input logic [ID_W-1:0] eoi_id,
    input logic        need_q,
    input logic [PRIO_W-1:0] cppr_q,
    input logic [ID_W-1:0]   xisr_q
);

    localparam logic [ID_W-1:0] IPI_SRC = ID_W'(IPI_ID);

    p_refuse_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_done && !offer_taken) |-> need_q);

    p_accept_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ACCEPT && !offer_valid) |=> (acc_valid && !irq_out));

    p_resend_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resend_req |-> ($past(op_valid) && $past(op_code) != OP_ACCEPT));

    p_equal_noop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SET_CPPR && op_prio == cppr_q && !offer_valid)
        |=> (cppr_q == $past(cppr_q) && xisr_q == $past(xisr_q) &&
             !op_rej_valid && !resend_req));

    p_eoi_skip_ipi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> (eoi_id != IPI_SRC));

    p_op_rej_real_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_rej_valid |-> (op_rej_id != IPI_SRC && op_rej_id != '0));

    p_off_rej_real_r10: assert property (@(posedge clk) disable iff (!rst_n)
        off_rej_valid |-> (off_rej_id != IPI_SRC && off_rej_id != '0 && offer_taken));

    p_offer_answer_r12: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |=> offer_done);

    p_no_stray_answer_r12: assert property (@(posedge clk) disable iff (!rst_n)
        offer_done |-> $past(offer_valid));

endmodule

bind irq_presenter ipr_checker #(.IPI_ID(IPI_ID)) u_ipr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_code       (op_code),
    .op_prio       (op_data[irq_presenter_pkg::PRIO_W-1:0]),
    .offer_valid   (offer_valid),
    .irq_out       (irq_out),
    .acc_valid     (acc_valid),
    .offer_done    (offer_done),
    .offer_taken   (offer_taken),
    .op_rej_valid  (op_rej_valid),
    .op_rej_id     (op_rej_id),
    .off_rej_valid (off_rej_valid),
    .off_rej_id    (off_rej_id),
    .resend_req    (resend_req),
    .eoi_valid     (eoi_valid),
    .eoi_id        (eoi_id),
    .need_q        (state_q.need),
    .cppr_q        (state_q.cppr),
    .xisr_q        (state_q.xisr)
);

// File: tb/test_irq_presenter.sv
module test_irq_presenter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = '0;
    logic [31:0] op_data = '0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_id = '0;
    logic [7:0]  offer_prio = '0;
    logic        irq_out, acc_valid, offer_done, offer_taken;
    logic [31:0] acc_word;
    logic        op_rej_valid, off_rej_valid, resend_req, eoi_valid;
    logic [23:0] op_rej_id, off_rej_id, eoi_id;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_presenter i_irq_presenter (
        .clk (clk), .rst_n (rst_n),
        .op_valid (op_valid), .op_code (op_code), .op_data (op_data),
        .offer_valid (offer_valid), .offer_id (offer_id), .offer_prio (offer_prio),
        .irq_out (irq_out), .acc_valid (acc_valid), .acc_word (acc_word),
        .offer_done (offer_done), .offer_taken (offer_taken),
        .op_rej_valid (op_rej_valid), .op_rej_id (op_rej_id),
        .off_rej_valid (off_rej_valid), .off_rej_id (off_rej_id),
        .resend_req (resend_req), .eoi_valid (eoi_valid), .eoi_id (eoi_id)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic ov, input logic [1:0] oc, input logic [31:0] od,
                        input logic fv, input logic [23:0] fid, input logic [7:0] fp);
        op_valid = ov; op_code = oc; op_data = od;
        offer_valid = fv; offer_id = fid; offer_prio = fp;
        @(negedge clk);
        op_valid = 1'b0; offer_valid = 1'b0;
    endtask

    task automatic op(input logic [1:0] oc, input logic [31:0] od);
        step(1'b1, oc, od, 1'b0, '0, '0);
    endtask

    task automatic offer(input logic [23:0] fid, input logic [7:0] fp);
        step(1'b0, 2'd0, '0, 1'b1, fid, fp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] cset [3];
        logic [7:0] mset [4];
        logic [7:0] pset [7];
        cset = '{8'd4, 8'd8, 8'd12};
        mset = '{8'd4, 8'd8, 8'd12, 8'hFF};
        pset = '{8'd3, 8'd4, 8'd7, 8'd8, 8'd11, 8'd12, 8'd13};

        do_reset();
        // R11 reset state: line low, accept returns threshold 0 and id 0
        check("R11 irq", {31'd0, irq_out}, 32'd0);
        op(2'd0, 32'd0);
        check("R11 acc_valid", {31'd0, acc_valid}, 32'd1);
        check("R11 acc_word", acc_word, 32'd0);

        // R1 / R3: take, displace, refuse
        op(2'd1, 32'hFF);
        offer(24'd100, 8'd5);
        check("R1 taken", {31'd0, offer_taken}, 32'd1);
        check("R1 no reject", {31'd0, off_rej_valid}, 32'd0);
        check("R3 irq", {31'd0, irq_out}, 32'd1);
        offer(24'd200, 8'd3);
        check("R1 displace valid", {31'd0, off_rej_valid}, 32'd1);
        check("R1 displace id", {8'd0, off_rej_id}, 32'd100);
        offer(24'd300, 8'd4);
        check("R1 refuse", {31'd0, offer_taken}, 32'd0);
        check("R1 done", {31'd0, offer_done}, 32'd1);

        // R8 smaller threshold rejects, equal is a no-op; R7 raise resends
        op(2'd1, 32'd3);
        check("R8 reject valid", {31'd0, op_rej_valid}, 32'd1);
        check("R8 reject id", {8'd0, op_rej_id}, 32'd200);
        check("R8 irq low", {31'd0, irq_out}, 32'd0);
        op(2'd1, 32'd3);
        check("R8 equal no reject", {31'd0, op_rej_valid}, 32'd0);
        check("R8 equal no resend", {31'd0, resend_req}, 32'd0);
        op(2'd1, 32'h10);
        check("R7 resend", {31'd0, resend_req}, 32'd1);
        op(2'd1, 32'h20);
        check("R7 flag cleared", {31'd0, resend_req}, 32'd0);

        // R5 / R4
        do_reset();
        op(2'd1, 32'hFF);
        offer(24'd300, 8'd9);
        op(2'd2, 32'd6);
        check("R5 reject valid", {31'd0, op_rej_valid}, 32'd1);
        check("R5 reject id", {8'd0, op_rej_id}, 32'd300);
        check("R5 irq", {31'd0, irq_out}, 32'd1);
        op(2'd0, 32'd0);
        check("R4 acc_word", acc_word, 32'hFF000002);
        check("R4 irq cleared", {31'd0, irq_out}, 32'd0);
        op(2'd0, 32'd0);
        check("R4 empty accept", acc_word, 32'h06000000);

        // R10: an offer displacing the inter-processor request reports nothing
        do_reset();
        op(2'd1, 32'hFF);
        op(2'd2, 32'd6);
        check("R10 no op reject", {31'd0, op_rej_valid}, 32'd0);
        offer(24'd50, 8'd2);
        check("R10 taken", {31'd0, offer_taken}, 32'd1);
        check("R10 no offer reject", {31'd0, off_rej_valid}, 32'd0);
        op(2'd0, 32'd0);
        check("R10 acc_word", acc_word, 32'hFF000032);

        // R9 end-of-interrupt
        op(2'd3, 32'h2000004D);
        check("R9 forward", {31'd0, eoi_valid}, 32'd1);
        check("R9 forward id", {8'd0, eoi_id}, 32'd77);
        op(2'd3, 32'h20000002);
        check("R9 ipi not forwarded", {31'd0, eoi_valid}, 32'd0);
        do_reset();
        op(2'd1, 32'd5);
        offer(24'd60, 8'd9);
        check("R2 refused", {31'd0, offer_taken}, 32'd0);
        op(2'd3, 32'hFF00004D);
        check("R9 eoi resend", {31'd0, resend_req}, 32'd1);

        // R7 threshold raise makes the inter-processor request pending
        do_reset();
        op(2'd2, 32'd5);
        op(2'd1, 32'd10);
        check("R7 irq", {31'd0, irq_out}, 32'd1);
        op(2'd0, 32'd0);
        check("R7 acc_word", acc_word, 32'h0A000002);

        // R12 same cycle: operation first
        do_reset();
        op(2'd1, 32'hFF);
        step(1'b1, 2'd1, 32'd4, 1'b1, 24'd70, 8'd6);
        check("R12 refused after op", {31'd0, offer_taken}, 32'd0);
        offer(24'd80, 8'd3);
        step(1'b1, 2'd0, 32'd0, 1'b1, 24'd90, 8'd2);
        check("R12 acc_word", acc_word, 32'h04000050);
        check("R12 taken", {31'd0, offer_taken}, 32'd1);
        check("R12 no reject", {31'd0, off_rej_valid}, 32'd0);

        // Sweep: R1 bounds, R3 line, R4 word, R2/R6 redelivery
        foreach (cset[ci]) foreach (mset[mi]) foreach (pset[pi]) begin
            logic [7:0]  c, m, p, pend;
            logic        tk, ipi;
            logic [23:0] id, xexp;
            c = cset[ci]; m = mset[mi]; p = pset[pi];
            id = 24'h100 + {16'd0, p};
            ipi = (m < c);
            pend = ipi ? m : 8'hFF;
            tk = (p < c) && (p < m) && (p < pend);
            do_reset();
            op(2'd1, {24'd0, c});
            op(2'd2, {24'd0, m});
            offer(id, p);
            check("R1 sweep taken", {31'd0, offer_taken}, {31'd0, tk});
            check("R10 sweep reject", {31'd0, off_rej_valid}, 32'd0);
            check("R3 sweep irq", {31'd0, irq_out}, {31'd0, tk | ipi});
            xexp = tk ? id : (ipi ? 24'd2 : 24'd0);
            op(2'd0, 32'd0);
            check("R4 sweep word", acc_word, {c, xexp});
            op(2'd2, 32'hFF);
            check("R6 sweep resend", {31'd0, resend_req}, {31'd0, (m != 8'hFF) && !tk});
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule